// File: doc/BRIEF.md
# Crosspoint Parallel Command Controller

This block is the digital control core of an eight-output, eight-input crosspoint switch. A host drives one word at a time onto a parallel bus: a 3-bit output address and a 4-bit command code. It then raises a write strobe. The strobe counts only while both chip enables are asserted. Codes with the top bit clear name an input channel for the addressed output. One further code ties the addressed output buffer's input to ground. The remaining codes switch buffers on or off, singly or all together, or act as a software latch.

Routing words go first into a per-output holding rank. A second rank drives the switch-select, ground-select and buffer-enable outputs. The holding rank is copied into the second rank all at once, so every output takes its new setting in the same cycle. The copy happens on any of these:
- the rising edge of a latch input, in edge mode;
- continuously while the latch input is low, in level mode;
- whenever a buffer-control command runs;
- on the software-latch code while the latch input is held high.

The write strobe, chip enables and latch pin are asynchronous. They pass through a two-flop synchronizer on the system clock, and their edges are detected there. Address and code must be stable from the strobe's rise until it has been seen.

Top module: `xpt_cmd_ctrl`

## Requirements
- R1: A write acts only when `ce_hi` is 1 and `ce_lo_n` is 0 while `wr_strobe` rises. With either enable inactive, a write leaves every output unchanged.
- R2: A code 0b0xxx written to output k is stored, and after the next transfer `sel_chan[3k+2:3k]` equals xxx and `gnd_sel[k]` is 0.
- R3: Code 0b1000 written to output k gives `gnd_sel[k]` = 1 and `sel_chan` field k = 0 after the next transfer.
- R4: With `edge_mode` = 1, the routing outputs change only after a rising edge of `latch_in` or a buffer-control or software-latch command. Until then, writes of routing codes stay invisible. One transfer updates every output in the same cycle.
- R5: With `edge_mode` = 0, the routing outputs follow the stored codes while `latch_in` is low, and hold while it is high.
- R6: Code 0b1011 clears `buf_en` for the addressed output only. It also copies the holding rank into the second rank.
- R7: Code 0b1100 sets `buf_en` for the addressed output only. It also copies the holding rank into the second rank.
- R8: Code 0b1101 clears every `buf_en` bit and code 0b1110 sets every bit. Both also copy the holding rank into the second rank.
- R9: Code 0b1111 copies the holding rank into the second rank when `latch_in` is high, and does nothing when `latch_in` is low.
- R10: Codes 0b1001 and 0b1010 change neither `buf_en` nor the routing outputs.
- R11: While `rst_n` is low, and right after reset, `buf_en` is all zero. Routing registers are not preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe | input | 1 | Asynchronous write strobe; acts on its rising edge |
| ce_hi | input | 1 | Active-high chip enable |
| ce_lo_n | input | 1 | Active-low chip enable |
| latch_in | input | 1 | Asynchronous second-rank latch pin |
| edge_mode | input | 1 | 1: transfer on latch rising edge; 0: transparent while latch low |
| out_addr | input | 3 | Output address of the word |
| cmd_code | input | 4 | Command code of the word |
| sel_chan | output | 24 | Input channel selected per output, 3 bits each, output 0 in the low bits |
| gnd_sel | output | 8 | Per-output ground select of the buffer input |
| buf_en | output | 8 | Per-output buffer enable |

## Verification
The routing path is tried with three kinds of pattern:
- A distinct channel is staged on every output before one latch pulse. This separates a correct simultaneous transfer from a wrong address decode or a premature copy.
- Routing writes follow a transfer. These show that staged data stays hidden until the next trigger in edge mode, and flows straight through in level mode.
- Buffer commands are interleaved with routing writes. Single-output disable and enable must leave neighbours alone and still pull staged routing through.

The reserved codes, the software latch with the latch pin low and high, and writes with either chip enable inactive tell ignored words apart from acted-on words.

// File: rtl/xpt_pkg.sv
// Shared command encodings and decoded-control type for the crosspoint
// command controller. Assumes a 4-bit code whose top bit flags a command.
package xpt_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        C_GND      = 4'b1000,
        C_RSV_A    = 4'b1001,
        C_RSV_B    = 4'b1010,
        C_OFF_ONE  = 4'b1011,
        C_ON_ONE   = 4'b1100,
        C_OFF_ALL  = 4'b1101,
        C_ON_ALL   = 4'b1110,
        C_SOFT_LAT = 4'b1111
    } cmd_e;

    typedef struct packed {
        logic store;      // write code into holding rank
        logic off_one;
        logic on_one;
        logic off_all;
        logic on_all;
        logic xfer;       // copy holding rank into second rank
    } dec_t;
endpackage

// File: rtl/xpt_edge_sync.sv
// Brings an asynchronous pin into the clock domain through STAGES flops
// and flags its rising edge for one cycle. Assumes pulses on the pin last
// longer than one clock period.
module xpt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shr;

    // Shift the pin through the synchronizer and one edge-detect flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shr <= '0;
        else        shr <= {shr[DEPTH-2:0], pin};
    end

    assign level = shr[STAGES-1];
    assign rise  = shr[STAGES-1] & ~shr[STAGES];
endmodule

// File: rtl/xpt_cmd_decode.sv
// Turns a detected write and its code into one-cycle control strobes.
// Assumes the code is stable in the cycle the write is detected.
module xpt_cmd_decode
    import xpt_pkg::*;
(
    input  logic              wr_go,
    input  logic [CODE_W-1:0] code,
    input  logic              latch_lvl,
    output dec_t              dec
);
    // Decode the command; reserved codes produce no strobe.
    always_comb begin
        dec         = '0;
        dec.store   = wr_go & (~code[CODE_W-1] | (code == C_GND));
        dec.off_one = wr_go & (code == C_OFF_ONE);
        dec.on_one  = wr_go & (code == C_ON_ONE);
        dec.off_all = wr_go & (code == C_OFF_ALL);
        dec.on_all  = wr_go & (code == C_ON_ALL);
        dec.xfer    = dec.off_one | dec.on_one | dec.off_all | dec.on_all |
                      (wr_go & (code == C_SOFT_LAT) & latch_lvl);
    end
endmodule

// File: rtl/xpt_rank_regs.sv
// Holding rank, second rank and buffer enables for NUM_OUT outputs.
// Routing ranks carry no reset by intent; only the enables are cleared.
module xpt_rank_regs
    import xpt_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int ADDR_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  dec_t                          dec,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [CODE_W-1:0]             code,
    input  logic                          edge_mode,
    input  logic                          latch_lvl,
    input  logic                          latch_rise,
    output logic [NUM_OUT-1:0][CODE_W-1:0] rank2,
    output logic [NUM_OUT-1:0]            buf_en
);
    logic [NUM_OUT-1:0][CODE_W-1:0] rank1;
    logic                           load2;

    // Second-rank trigger: command, edge-mode pin edge, or level-mode low.
    assign load2 = dec.xfer | (edge_mode ? latch_rise : ~latch_lvl);

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);

        // Capture a routing or ground code addressed to this output.
        always_ff @(posedge clk) begin
            if (dec.store && addr == MY_ADDR) rank1[g] <= code;
        end

        // Copy this output's holding entry on a transfer.
        always_ff @(posedge clk) begin
            if (load2) rank2[g] <= rank1[g];
        end

        // Track this output's buffer enable; bulk commands take priority.
        always_ff @(posedge clk) begin
            if (!rst_n)                              buf_en[g] <= 1'b0;
            else if (dec.off_all)                    buf_en[g] <= 1'b0;
            else if (dec.on_all)                     buf_en[g] <= 1'b1;
            else if (dec.off_one && addr == MY_ADDR) buf_en[g] <= 1'b0;
            else if (dec.on_one && addr == MY_ADDR)  buf_en[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/xpt_cmd_ctrl.sv
// Top of the crosspoint parallel command controller. Qualifies the write
// strobe with both chip enables, synchronizes it and the latch pin, decodes
// the word and drives per-output routing and buffer enables.
module xpt_cmd_ctrl
    import xpt_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int NUM_IN  = 8,
    parameter int STAGES  = 2,
    localparam int ADDR_W = $clog2(NUM_OUT),
    localparam int SEL_W  = $clog2(NUM_IN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_strobe,
    input  logic                     ce_hi,
    input  logic                     ce_lo_n,
    input  logic                     latch_in,
    input  logic                     edge_mode,
    input  logic [ADDR_W-1:0]        out_addr,
    input  logic [CODE_W-1:0]        cmd_code,
    output logic [NUM_OUT*SEL_W-1:0] sel_chan,
    output logic [NUM_OUT-1:0]       gnd_sel,
    output logic [NUM_OUT-1:0]       buf_en
);
    logic wr_pin, wr_lvl, wr_go, latch_lvl, latch_rise;
    dec_t dec;
    logic [NUM_OUT-1:0][CODE_W-1:0] rank2;

    assign wr_pin = wr_strobe & ce_hi & ~ce_lo_n;

    xpt_edge_sync #(.STAGES(STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .pin(wr_pin), .level(wr_lvl), .rise(wr_go)
    );

    xpt_edge_sync #(.STAGES(STAGES)) u_lat_sync (
        .clk(clk), .rst_n(rst_n), .pin(latch_in), .level(latch_lvl), .rise(latch_rise)
    );

    xpt_cmd_decode u_dec (
        .wr_go(wr_go), .code(cmd_code), .latch_lvl(latch_lvl), .dec(dec)
    );

    xpt_rank_regs #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_ranks (
        .clk(clk), .rst_n(rst_n), .dec(dec), .addr(out_addr), .code(cmd_code),
        .edge_mode(edge_mode), .latch_lvl(latch_lvl), .latch_rise(latch_rise),
        .rank2(rank2), .buf_en(buf_en)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_map
        assign sel_chan[g*SEL_W +: SEL_W] = rank2[g][SEL_W-1:0];
        assign gnd_sel[g]                 = rank2[g][CODE_W-1];
    end

    logic unused_lvl;
    assign unused_lvl = wr_lvl;
endmodule

// File: rtl/xpt_cmd_ctrl_chk.sv
// Assertion checker for xpt_cmd_ctrl, attached by bind. Observes the
// detected write and latch edges plus the block's outputs.
module xpt_cmd_ctrl_chk #(
    parameter int NUM_OUT = 8,
    parameter int SEL_W   = 3,
    parameter int ADDR_W  = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_go,
    input logic                     latch_rise,
    input logic                     edge_mode,
    input logic [ADDR_W-1:0]        out_addr,
    input logic [3:0]               cmd_code,
    input logic [NUM_OUT*SEL_W-1:0] sel_chan,
    input logic [NUM_OUT-1:0]       gnd_sel,
    input logic [NUM_OUT-1:0]       buf_en
);
    // R11
    rst_bufs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> buf_en == '0);

    // R10
    rsv_code_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && (cmd_code == 4'b1001 || cmd_code == 4'b1010) |=> $stable(buf_en));

    // R6
    off_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && cmd_code == 4'b1011 |=> !buf_en[$past(out_addr)]);

    // R7
    on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && cmd_code == 4'b1100 |=> buf_en[$past(out_addr)]);

    // R8
    off_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && cmd_code == 4'b1101 |=> buf_en == '0);

    // R8
    on_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && cmd_code == 4'b1110 |=> buf_en == '1);

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode && !latch_rise && !wr_go |=> $stable(sel_chan) && $stable(gnd_sel));
endmodule

bind xpt_cmd_ctrl xpt_cmd_ctrl_chk #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .latch_rise(latch_rise),
    .edge_mode(edge_mode), .out_addr(out_addr), .cmd_code(cmd_code),
    .sel_chan(sel_chan), .gnd_sel(gnd_sel), .buf_en(buf_en)
);

// File: tb/xpt_cmd_ctrl_bench.sv
module xpt_cmd_ctrl_bench;
    localparam int PER = 8;
    localparam int NV  = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_strobe = 1'b0, ce_hi = 1'b1, ce_lo_n = 1'b0;
    logic latch_in = 1'b0, edge_mode = 1'b1;
    logic [2:0] out_addr = '0;
    logic [3:0] cmd_code = '0;
    logic [23:0] sel_chan;
    logic [7:0]  gnd_sel, buf_en;
    int total = 0, bad = 0;

    always #(PER/2) clk = ~clk;

    xpt_cmd_ctrl u_xpt_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .ce_hi(ce_hi),
        .ce_lo_n(ce_lo_n), .latch_in(latch_in), .edge_mode(edge_mode),
        .out_addr(out_addr), .cmd_code(cmd_code), .sel_chan(sel_chan),
        .gnd_sel(gnd_sel), .buf_en(buf_en)
    );

    // {req(4), kind(1: latch pulse), addr(3), code(4), chk(1), cout(3), sel(3), gnd(1), en(8)}
    localparam logic [27:0] VEC [NV] = '{
        {4'd2, 1'b0, 3'd0, 4'b0011, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00}, // R2 staging
        {4'd2, 1'b0, 3'd1, 4'b0101, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00},
        {4'd3, 1'b0, 3'd2, 4'b1000, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00},
        {4'd2, 1'b0, 3'd3, 4'b0111, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00},
        {4'd2, 1'b0, 3'd4, 4'b0000, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00},
        {4'd2, 1'b0, 3'd5, 4'b0001, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00},
        {4'd2, 1'b0, 3'd6, 4'b0110, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00},
        {4'd2, 1'b0, 3'd7, 4'b0010, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00},
        {4'd4, 1'b1, 3'd0, 4'b0000, 1'b1, 3'd0, 3'd3, 1'b0, 8'h00}, // R4 latch pulse
        {4'd8, 1'b0, 3'd0, 4'b1110, 1'b1, 3'd1, 3'd5, 1'b0, 8'hFF}, // R8 all on
        {4'd6, 1'b0, 3'd2, 4'b1011, 1'b1, 3'd2, 3'd0, 1'b1, 8'hFB}, // R6, R3
        {4'd4, 1'b0, 3'd0, 4'b0110, 1'b1, 3'd0, 3'd3, 1'b0, 8'hFB}, // R4 staged only
        {4'd7, 1'b0, 3'd2, 4'b1100, 1'b1, 3'd0, 3'd6, 1'b0, 8'hFF}, // R7 loads too
        {4'd10,1'b0, 3'd7, 4'b1001, 1'b1, 3'd7, 3'd2, 1'b0, 8'hFF}, // R10
        {4'd10,1'b0, 3'd7, 4'b1010, 1'b1, 3'd7, 3'd2, 1'b0, 8'hFF}, // R10
        {4'd4, 1'b0, 3'd1, 4'b0100, 1'b1, 3'd1, 3'd5, 1'b0, 8'hFF}, // R4
        {4'd8, 1'b0, 3'd3, 4'b1101, 1'b1, 3'd1, 3'd4, 1'b0, 8'h00}, // R8 all off
        {4'd4, 1'b0, 3'd6, 4'b0001, 1'b1, 3'd6, 3'd6, 1'b0, 8'h00}, // R4
        {4'd9, 1'b0, 3'd4, 4'b1111, 1'b1, 3'd6, 3'd6, 1'b0, 8'h00}, // R9 latch low
        {4'd2, 1'b1, 3'd0, 4'b0000, 1'b1, 3'd6, 3'd1, 1'b0, 8'h00}  // R2
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [3:0] c);
        @(negedge clk);
        out_addr = a; cmd_code = c;
        wait_n(1); wr_strobe = 1'b1;
        wait_n(4); wr_strobe = 1'b0;
        wait_n(5);
    endtask

    task automatic do_latch_pulse();
        @(negedge clk); latch_in = 1'b1;
        wait_n(5); latch_in = 1'b0;
        wait_n(5);
    endtask

    function automatic logic [2:0] sel_of(input int k);
        return sel_chan[k*3 +: 3];
    endfunction

    initial begin
        wait_n(3);
        // R11: enables off during reset
        check(buf_en == 8'h00, "R11", buf_en, 0);
        rst_n = 1'b1;
        wait_n(2);
        check(buf_en == 8'h00, "R11", buf_en, 0);

        for (int v = 0; v < NV; v++) begin
            logic [27:0] e;
            e = VEC[v];
            if (e[23]) do_latch_pulse();
            else       do_write(e[22:20], e[19:16]);
            check(buf_en == e[7:0], $sformatf("R%0d", e[27:24]), buf_en, e[7:0]);
            if (e[15]) begin
                check(sel_of(int'(e[14:12])) == e[11:9], $sformatf("R%0d", e[27:24]),
                      sel_of(int'(e[14:12])), e[11:9]);
                check(gnd_sel[e[14:12]] == e[8], $sformatf("R%0d", e[27:24]),
                      gnd_sel[e[14:12]], e[8]);
            end
        end

        // R1: disqualified writes are dropped
        ce_hi = 1'b0; do_write(3'd0, 4'b1110);
        check(buf_en == 8'h00, "R1", buf_en, 0);
        ce_hi = 1'b1; ce_lo_n = 1'b1; do_write(3'd0, 4'b1110);
        check(buf_en == 8'h00, "R1", buf_en, 0);
        ce_lo_n = 1'b0; do_write(3'd0, 4'b1110);
        check(buf_en == 8'hFF, "R1", buf_en, 8'hFF);

        // R3: ground code
        do_write(3'd5, 4'b1000); do_latch_pulse();
        check(gnd_sel[5] == 1'b1 && sel_of(5) == 3'd0, "R3", {gnd_sel[5], sel_of(5)}, 4'h8);

        // R9: software latch with latch pin high
        @(negedge clk); latch_in = 1'b1; wait_n(6);
        do_write(3'd6, 4'b0011);
        check(sel_of(6) == 3'd1, "R4", sel_of(6), 1);
        do_write(3'd4, 4'b1111);
        check(sel_of(6) == 3'd3, "R9", sel_of(6), 3);

        // R5: level mode
        edge_mode = 1'b0;
        do_write(3'd3, 4'b0101);
        check(sel_of(3) == 3'd7, "R5", sel_of(3), 7);
        @(negedge clk); latch_in = 1'b0; wait_n(6);
        check(sel_of(3) == 3'd5, "R5", sel_of(3), 5);
        do_write(3'd3, 4'b0000);
        check(sel_of(3) == 3'd0, "R5", sel_of(3), 0);
        @(negedge clk); latch_in = 1'b1; wait_n(6);
        do_write(3'd3, 4'b0010);
        check(sel_of(3) == 3'd0, "R5", sel_of(3), 0);

        // R4: staged writes appear together on one pulse
        edge_mode = 1'b1;
        @(negedge clk); latch_in = 1'b0; wait_n(6);
        do_write(3'd0, 4'b0001); do_write(3'd1, 4'b0010);
        check(sel_of(0) == 3'd6 && sel_of(1) == 3'd4, "R4", {sel_of(0), sel_of(1)}, 6'o64);
        do_latch_pulse();
        check(sel_of(0) == 3'd1 && sel_of(1) == 3'd2, "R4", {sel_of(0), sel_of(1)}, 6'o12);

        // R11: reset mid-run
        @(negedge clk); rst_n = 1'b0; wait_n(3);
        check(buf_en == 8'h00, "R11", buf_en, 0);
        rst_n = 1'b1; wait_n(2);
        check(buf_en == 8'h00, "R11", buf_en, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PER * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule